// File: doc/BRIEF.md
# CAN Receive Frame Queue

This block is the three-entry holding area between a CAN receiver with acceptance filtering and the software that consumes frames. Each accepted frame carries its identifier, data length code, eight data bytes and the index of the filter that accepted it. The receive side presents a frame with a one-cycle valid strobe. Software sees the oldest stored frame on a set of mailbox outputs. It frees that frame with a one-cycle release pulse, and the next frame then appears.

Occupancy is shown as a 2-bit pending code, a full flag and an overrun flag. A lock-mode input chooses what happens when a frame arrives while all three entries are in use. With lock mode off, the new frame replaces the newest stored frame. With lock mode on, the new frame is dropped. A single interrupt output combines the three status conditions, and each condition has its own enable.

Top module: `can_rx_queue`

## Requirements
- R1: After reset the pending code is 00, the full and overrun flags are 0, the interrupt is 0 and all mailbox outputs are zero.
- R2: The pending code is the number of stored frames: 00 for none, 01 for one, 10 for two, 11 for three. Frames are kept in arrival order. The mailbox shows the oldest frame, and shows all zeros when the queue is empty.
- R3: A release pulse on a non-empty queue frees the oldest frame in the next cycle. The pending code drops by one and the mailbox shows the next frame.
- R4: A valid frame and a release in the same cycle on a non-empty queue store the frame and free the oldest one, so the pending code stays the same.
- R5: A release on an empty queue is ignored. A frame arriving in that same cycle is stored normally and gives pending code 01.
- R6: A store that leaves three frames pending sets the full flag.
- R7: The full flag clears on a release that leaves fewer than three frames pending, or when clear-full is pulsed. A set event in the same cycle wins over clear-full.
- R8: A valid frame arriving with three frames pending and no release sets the overrun flag, and the pending code stays 11. Clear-overrun resets the flag. A new overrun in the same cycle wins over the clear.
- R9: With lock mode off, an overrun replaces the newest stored frame with the arriving frame. The two older frames are kept.
- R10: With lock mode on, an overrun drops the arriving frame and keeps the three stored frames unchanged.
- R11: The interrupt equals (pending non-zero AND pending enable) OR (full AND full enable) OR (overrun AND overrun enable). It is combinational from the registered state and the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_en | input | 1 | Overrun policy: 1 drops the new frame, 0 replaces the newest frame |
| wr_valid | input | 1 | One-cycle strobe: an accepted frame is present |
| wr_id | input | ID_W | Identifier of the arriving frame |
| wr_dlc | input | DLC_W | Data length code of the arriving frame |
| wr_data | input | DATA_W | Payload of the arriving frame |
| wr_fmi | input | FMI_W | Index of the filter that accepted the frame |
| rel | input | 1 | One-cycle pulse that frees the oldest frame |
| clr_full | input | 1 | Pulse that clears the full flag |
| clr_ovr | input | 1 | Pulse that clears the overrun flag |
| ie_pend | input | 1 | Interrupt enable for a non-zero pending code |
| ie_full | input | 1 | Interrupt enable for the full flag |
| ie_ovr | input | 1 | Interrupt enable for the overrun flag |
| mb_id | output | ID_W | Identifier of the oldest frame |
| mb_dlc | output | DLC_W | Length code of the oldest frame |
| mb_data | output | DATA_W | Payload of the oldest frame |
| mb_fmi | output | FMI_W | Filter index of the oldest frame |
| pend | output | 2 | Pending frame count code |
| full | output | 1 | Full flag |
| ovr | output | 1 | Overrun flag |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check on every cycle how the pending code moves for each combination of store and release. They also check that the full and overrun flags are set when they should be, that the mailbox does not change across an overrun in lock mode, and that the interrupt never fires without a source. Some behaviour needs a whole scenario instead: that the frames come out in arrival order, which stored frame an overrun replaces when lock mode is off, and how the flag clears interact with set events in the same cycle. A scoreboard follows the frames in and out to show these.

// File: rtl/can_rx_queue_pkg.sv
package can_rx_queue_pkg;
  localparam int unsigned SLOTS = 3;
  typedef logic [1:0] slot_t;

  // advance a slot index by k positions, modulo the number of slots
  function automatic slot_t slot_add(input slot_t p, input logic [1:0] k);
    logic [2:0] s;
    s = {1'b0, p} + {1'b0, k};
    if (s >= 3'(SLOTS)) s = s - 3'(SLOTS);
    return s[1:0];
  endfunction

  // pending count after one cycle of store and release activity
  function automatic logic [1:0] cnt_after(input logic [1:0] c, input logic st, input logic pop);
    return c + {1'b0, st} - {1'b0, pop};
  endfunction
endpackage

// File: rtl/can_rx_queue_ctrl.sv
module can_rx_queue_ctrl
  import can_rx_queue_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_valid,
  input  logic  rel,
  input  logic  lock_en,
  input  logic  clr_full,
  input  logic  clr_ovr,
  output slot_t rd_ptr,
  output logic [1:0] cnt,
  output logic  we,
  output slot_t widx,
  output logic  full,
  output logic  ovr,
  output logic  ev_store,
  output logic  ev_pop,
  output logic  ev_ovr
);
  logic at_cap;
  logic ev_over;
  logic [1:0] cnt_nxt;

  always_comb begin
    at_cap   = (cnt == 2'd3);
    ev_pop   = rel && (cnt != 2'd0);
    ev_store = wr_valid && (!at_cap || ev_pop);
    ev_ovr   = wr_valid && at_cap && !ev_pop;
    ev_over  = ev_ovr && !lock_en;
    we       = ev_store || ev_over;
    widx     = ev_over ? slot_add(rd_ptr, 2'd2) : slot_add(rd_ptr, cnt);
    cnt_nxt  = cnt_after(cnt, ev_store, ev_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      cnt    <= '0;
      full   <= 1'b0;
      ovr    <= 1'b0;
    end else begin
      cnt <= cnt_nxt;
      if (ev_pop) rd_ptr <= slot_add(rd_ptr, 2'd1);
      if (ev_store && cnt_nxt == 2'd3) full <= 1'b1;
      else if ((ev_pop && cnt_nxt != 2'd3) || clr_full) full <= 1'b0;
      if (ev_ovr) ovr <= 1'b1;
      else if (clr_ovr) ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/can_rx_queue_store.sv
module can_rx_queue_store
  import can_rx_queue_pkg::*;
#(
  parameter int unsigned FRAME_W = 105
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  slot_t              widx,
  input  logic [FRAME_W-1:0] wframe,
  input  slot_t              ridx,
  input  logic               show,
  output logic [FRAME_W-1:0] rframe
);
  logic [FRAME_W-1:0] slot_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[g] <= '0;
      else if (we && widx == slot_t'(g)) slot_q[g] <= wframe;
    end
  end

  always_comb begin
    rframe = '0;
    for (int i = 0; i < SLOTS; i++)
      if (show && ridx == slot_t'(i)) rframe = slot_q[i];
  end
endmodule

// File: rtl/can_rx_queue_irq.sv
module can_rx_queue_irq (
  input  logic [1:0] cnt,
  input  logic       full,
  input  logic       ovr,
  input  logic       ie_pend,
  input  logic       ie_full,
  input  logic       ie_ovr,
  output logic       irq
);
  always_comb irq = ((cnt != 2'd0) && ie_pend) || (full && ie_full) || (ovr && ie_ovr);
endmodule

// File: rtl/can_rx_queue.sv
module can_rx_queue
  import can_rx_queue_pkg::*;
#(
  parameter int unsigned ID_W   = 29,
  parameter int unsigned DLC_W  = 4,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned FMI_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_en,
  input  logic              wr_valid,
  input  logic [ID_W-1:0]   wr_id,
  input  logic [DLC_W-1:0]  wr_dlc,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [FMI_W-1:0]  wr_fmi,
  input  logic              rel,
  input  logic              clr_full,
  input  logic              clr_ovr,
  input  logic              ie_pend,
  input  logic              ie_full,
  input  logic              ie_ovr,
  output logic [ID_W-1:0]   mb_id,
  output logic [DLC_W-1:0]  mb_dlc,
  output logic [DATA_W-1:0] mb_data,
  output logic [FMI_W-1:0]  mb_fmi,
  output logic [1:0]        pend,
  output logic              full,
  output logic              ovr,
  output logic              irq
);
  localparam int unsigned FRAME_W = ID_W + DLC_W + DATA_W + FMI_W;

  slot_t rd_ptr, widx;
  logic  we, ev_store, ev_pop, ev_ovr;
  logic [1:0] cnt;
  logic [FRAME_W-1:0] wframe, rframe;

  assign wframe = {wr_id, wr_dlc, wr_data, wr_fmi};

  can_rx_queue_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .rel(rel), .lock_en(lock_en),
    .clr_full(clr_full), .clr_ovr(clr_ovr), .rd_ptr(rd_ptr), .cnt(cnt), .we(we),
    .widx(widx), .full(full), .ovr(ovr), .ev_store(ev_store), .ev_pop(ev_pop),
    .ev_ovr(ev_ovr)
  );

  can_rx_queue_store #(.FRAME_W(FRAME_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(we), .widx(widx), .wframe(wframe),
    .ridx(rd_ptr), .show(cnt != 2'd0), .rframe(rframe)
  );

  can_rx_queue_irq u_irq (
    .cnt(cnt), .full(full), .ovr(ovr), .ie_pend(ie_pend), .ie_full(ie_full),
    .ie_ovr(ie_ovr), .irq(irq)
  );

  assign {mb_id, mb_dlc, mb_data, mb_fmi} = rframe;
  assign pend = cnt;
endmodule

// File: rtl/can_rx_queue_chk.sv
module can_rx_queue_chk #(
  parameter int unsigned ID_W = 29
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_valid,
  input logic            rel,
  input logic            lock_en,
  input logic [1:0]      pend,
  input logic            full,
  input logic            ovr,
  input logic            irq,
  input logic [ID_W-1:0] mb_id,
  input logic            ev_ovr
);
  AST_PEND_INC: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !rel && pend != 2'd3 |=> pend == $past(pend) + 2'd1); // R2
  AST_REL_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    rel && !wr_valid && pend != 2'd0 |=> pend == $past(pend) - 2'd1); // R3
  AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && rel && pend != 2'd0 |=> pend == $past(pend)); // R4
  AST_EMPTY_REL: assert property (@(posedge clk) disable iff (!rst_n)
    rel && !wr_valid && pend == 2'd0 |=> pend == 2'd0); // R5
  AST_FULL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    pend == 2'd2 && wr_valid && !rel |=> full); // R6
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    pend == 2'd3 && wr_valid && !rel |=> ovr && pend == 2'd3); // R8
  AST_OVR_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovr |=> ovr); // R8
  AST_LOCK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    pend == 2'd3 && wr_valid && !rel && lock_en |=> $stable(mb_id)); // R10
  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend != 2'd0 || full || ovr)); // R11
endmodule

bind can_rx_queue can_rx_queue_chk #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .rel(rel), .lock_en(lock_en),
  .pend(pend), .full(full), .ovr(ovr), .irq(irq), .mb_id(mb_id), .ev_ovr(ev_ovr)
);

// File: tb/sim_can_rx_queue.sv
module sim_can_rx_queue;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 105;
  typedef logic [FW-1:0] frame_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lock_en = 0, wr_valid = 0, rel = 0, clr_full = 0, clr_ovr = 0;
  logic ie_pend = 0, ie_full = 0, ie_ovr = 0;
  logic [28:0] wr_id = '0, mb_id;
  logic [3:0]  wr_dlc = '0, mb_dlc;
  logic [63:0] wr_data = '0, mb_data;
  logic [7:0]  wr_fmi = '0, mb_fmi;
  logic [1:0]  pend;
  logic        full, ovr, irq;

  int checks = 0, failures = 0;
  frame_t exp_q[$];
  logic exp_full = 0, exp_ovr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_rx_queue u0 (
    .clk(clk), .rst_n(rst_n), .lock_en(lock_en), .wr_valid(wr_valid), .wr_id(wr_id),
    .wr_dlc(wr_dlc), .wr_data(wr_data), .wr_fmi(wr_fmi), .rel(rel), .clr_full(clr_full),
    .clr_ovr(clr_ovr), .ie_pend(ie_pend), .ie_full(ie_full), .ie_ovr(ie_ovr),
    .mb_id(mb_id), .mb_dlc(mb_dlc), .mb_data(mb_data), .mb_fmi(mb_fmi),
    .pend(pend), .full(full), .ovr(ovr), .irq(irq)
  );

  function automatic frame_t mk(input int n);
    return {29'(n * 37 + 5), 4'(n % 9), {8{8'(n)}}, 8'(n + 1)};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    frame_t head;
    head = (exp_q.size() != 0) ? exp_q[0] : '0;
    chk({req, " pend"}, 128'(pend), 128'(exp_q.size()));
    chk({req, " full"}, 128'(full), 128'(exp_full));
    chk({req, " ovr"}, 128'(ovr), 128'(exp_ovr));
    chk({req, " mailbox"}, 128'({mb_id, mb_dlc, mb_data, mb_fmi}), 128'(head));
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    wr_valid = 0; rel = 0; clr_full = 0; clr_ovr = 0;
  endtask

  // driver: presents a frame, optionally with a release, and updates the expected queue
  task automatic drive(input int n, input bit with_rel, input bit with_clr_full, input bit with_clr_ovr);
    frame_t f;
    bit popped, set_full, set_ovr;
    f = mk(n);
    {wr_id, wr_dlc, wr_data, wr_fmi} = f;
    wr_valid = 1; rel = with_rel; clr_full = with_clr_full; clr_ovr = with_clr_ovr;
    popped = with_rel && exp_q.size() != 0;
    set_full = 0; set_ovr = 0;
    if (popped) void'(exp_q.pop_front());
    if (exp_q.size() < 3) begin
      exp_q.push_back(f);
      if (exp_q.size() == 3) set_full = 1;
    end else begin
      set_ovr = 1;
      if (!lock_en) exp_q[2] = f;
    end
    if (set_full) exp_full = 1;
    else if ((popped && exp_q.size() != 3) || with_clr_full) exp_full = 0;
    if (set_ovr) exp_ovr = 1;
    else if (with_clr_ovr) exp_ovr = 0;
    cyc();
  endtask

  // monitor: compares the mailbox with the oldest expected frame, then releases it
  task automatic take(input string req);
    frame_t e;
    e = (exp_q.size() != 0) ? exp_q[0] : '0;
    chk({req, " oldest"}, 128'({mb_id, mb_dlc, mb_data, mb_fmi}), 128'(e));
    rel = 1;
    if (exp_q.size() != 0) begin
      void'(exp_q.pop_front());
      if (exp_q.size() != 3) exp_full = 0;
    end
    cyc();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_state("R1");
    chk("R1 irq", 128'(irq), 128'(0));

    // fill in order; the full flag sets on the third store
    drive(1, 0, 0, 0); chk_state("R2 one");
    drive(2, 0, 0, 0); chk_state("R2 two");
    drive(3, 0, 0, 0); chk_state("R6 three");

    // interrupt gating
    ie_pend = 1; #1; chk("R11 pend", 128'(irq), 128'(1));
    ie_pend = 0; #1; chk("R11 off", 128'(irq), 128'(0));
    ie_full = 1; #1; chk("R11 full", 128'(irq), 128'(1));
    ie_full = 0; ie_ovr = 1; #1; chk("R11 ovr clear", 128'(irq), 128'(0));

    // overrun with lock off replaces the newest frame
    drive(4, 0, 0, 0); chk_state("R8 R9 overrun");
    chk("R11 ovr", 128'(irq), 128'(1));
    ie_ovr = 0;
    take("R9 first"); chk_state("R7 R3 after release");
    take("R9 second");
    take("R9 newest");
    chk_state("R3 empty");

    clr_ovr = 1; exp_ovr = 0; cyc(); chk_state("R8 clear");

    // release on empty is ignored
    rel = 1; cyc(); chk_state("R5 empty release");
    drive(5, 1, 0, 0); chk_state("R5 store with empty release");
    drive(6, 1, 0, 0); chk_state("R4 store and release");
    take("R4 drain");

    // lock on: the arriving frame is dropped
    lock_en = 1;
    drive(7, 0, 0, 0); drive(8, 0, 0, 0); drive(9, 0, 0, 0);
    drive(10, 0, 0, 1); chk_state("R8 R10 overrun wins over clear");
    drive(11, 1, 0, 0); chk_state("R4 R6 full store and release");
    clr_full = 1; exp_full = 0; cyc(); chk_state("R7 clear full");
    take("R10 a"); take("R10 b"); take("R10 c");
    chk_state("R10 drained");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule